// File: doc/BRIEF.md
# Configuration Frame XOR Merge Engine

This block merges a partial configuration image into a device's live configuration memory. It does not overwrite whole frames. It works frame by frame over a contiguous range. For each frame it takes the partial frame from an input stream, pulls the current contents of that frame back from the configuration port, and XORs the two together. The XOR is applied only for the words whose rows fall inside a selected row window. It then streams the merged frame back out on the write side before it moves on to the next frame.

Because the merge is an XOR, running the same operation a second time returns the configuration to its earlier state. The same partial data therefore both loads and removes a module. A row shift moves the partial rows to other device rows, so a module can be placed at more than one vertical position. A module can also be built up in several passes and removed by running those passes in reverse.

A single command opens one burst for the whole range. The readback stream starts with one pad frame, which the engine discards. The writeback stream ends with one pad frame of zero words, which the engine emits.

Top module: `cfg_xor_merge`

## Requirements
- R1: After reset, busy, done, err, the command strobe, the read ready, the partial ready and the write valid are all low.
- R2: A start seen while idle with a legal setup raises the command strobe for exactly one cycle, carrying the start frame and the frame count. Busy is high from the next cycle until the trailing pad has been written.
- R3: The first frame of readback words after a command (FRAME_WORDS words) is consumed and discarded. Exactly (count+1)·FRAME_WORDS readback words are consumed per operation.
- R4: For each frame the engine accepts exactly FRAME_WORDS partial words before it consumes that frame's readback. count·FRAME_WORDS partial words are taken in total.
- R5: A written word whose device row d satisfies lo ≤ d−shift ≤ hi equals the readback word XOR the partial word at index (word − shift·ROW_WORDS). Device row d covers word indices d·ROW_WORDS to d·ROW_WORDS+ROW_WORDS−1 within a frame.
- R6: Words whose device row lies outside the shifted window are written back exactly as read.
- R7: With a shift s, partial row p is merged into device row p+s.
- R8: After the last real frame, FRAME_WORDS all-zero words are written. The total number of written words is (count+1)·FRAME_WORDS.
- R9: done is a single-cycle pulse in the first cycle after busy falls.
- R10: A start with count 0, lo > hi, or hi+shift ≥ ROWS sets err and causes no command, no busy and no write. The next accepted start clears err.
- R11: Running an identical merge twice leaves the configuration unchanged.
- R12: A start asserted while busy is ignored.
- R13: Several passes over the same frames, removed by repeating them in reverse order, restore the original contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation |
| cfg_first_i | input | FADDR_W | First frame address |
| cfg_count_i | input | CNT_W | Number of real frames |
| cfg_row_lo_i | input | ROW_W | Lowest partial row merged |
| cfg_row_hi_i | input | ROW_W | Highest partial row merged |
| cfg_shift_i | input | ROW_W | Row offset added to partial rows |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last start rejected for an illegal window |
| pin_valid_i | input | 1 | Partial word available |
| pin_data_i | input | WORD_W | Partial word |
| pin_ready_o | output | 1 | Partial word accepted |
| cp_cmd_o | output | 1 | Burst command strobe |
| cp_frame_o | output | FADDR_W | Burst start frame |
| cp_count_o | output | CNT_W | Burst real frame count |
| cp_rd_valid_i | input | 1 | Readback word available |
| cp_rd_data_i | input | WORD_W | Readback word |
| cp_rd_ready_o | output | 1 | Readback word accepted |
| cp_wr_valid_o | output | 1 | Write word valid |
| cp_wr_data_o | output | WORD_W | Write word |

## Verification
The assertions assume that the configuration port opens a burst only in response to the command strobe. They also assume that it presents the pad frame first and then the real frames in address order, and that it accepts every write word in the cycle it is offered. They further assume that the setup inputs are stable during the cycle in which start is high. The bench port model answers each command with exactly that burst. Its pad words are non-zero, so a failure to discard the pad shows up as corrupted data. The bench changes the setup only on falling edges, together with start, and every random setup is drawn inside the legal window unless a rejection is being tested on purpose.

// File: rtl/xm_pkg.sv
package xm_pkg;

   typedef enum logic [2:0] {
      XM_IDLE  = 3'd0,
      XM_PAD   = 3'd1,
      XM_LOAD  = 3'd2,
      XM_MERGE = 3'd3,
      XM_TAIL  = 3'd4
   } xm_state_e;

endpackage

// File: rtl/xm_pbuf.sv
module xm_pbuf #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [WORD_W-1:0] rdata_o
);

   logic [WORD_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) store[waddr_i] <= wdata_i;
   end

   assign rdata_o = store[raddr_i];

endmodule

// File: rtl/xm_rowmap.sv
module xm_rowmap #(
   parameter int ROWS      = 4,
   parameter int ROW_WORDS = 2,
   localparam int FRAME_WORDS = ROWS * ROW_WORDS,
   localparam int WIDX_W      = $clog2(FRAME_WORDS),
   localparam int ROW_W       = $clog2(ROWS)
) (
   input  logic [WIDX_W-1:0] widx_i,
   input  logic [ROW_W-1:0]  lo_i,
   input  logic [ROW_W-1:0]  hi_i,
   input  logic [ROW_W-1:0]  shift_i,
   output logic              hit_o,
   output logic [WIDX_W-1:0] pidx_o
);

   logic [ROW_W:0]   lo_x, hi_x, sh_x;
   logic [ROWS-1:0]  row_hit;
   logic [ROW_W-1:0] row_idx;
   logic [WIDX_W:0]  word_off;
   logic [WIDX_W:0]  pidx_full;

   assign lo_x = {1'b0, lo_i};
   assign hi_x = {1'b0, hi_i};
   assign sh_x = {1'b0, shift_i};

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam logic [ROW_W:0] RV = (ROW_W+1)'(r);
      assign row_hit[r] = (RV >= sh_x) && ((RV - sh_x) >= lo_x) && ((RV - sh_x) <= hi_x);
   end

   assign row_idx   = ROW_W'(32'(widx_i) / ROW_WORDS);
   assign word_off  = (WIDX_W+1)'(32'(shift_i) * ROW_WORDS);
   assign pidx_full = {1'b0, widx_i} - word_off;

   assign hit_o  = row_hit[row_idx];
   assign pidx_o = pidx_full[WIDX_W-1:0];

endmodule

// File: rtl/xm_seq.sv
module xm_seq import xm_pkg::*; #(
   parameter int FRAME_WORDS = 8,
   parameter int CNT_W       = 8,
   localparam int WIDX_W     = $clog2(FRAME_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cfg_ok_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              pin_valid_i,
   input  logic              rd_valid_i,
   output logic              accept_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              cmd_o,
   output logic              pin_ready_o,
   output logic              rd_ready_o,
   output logic              load_fire_o,
   output logic              merge_fire_o,
   output logic              tail_o,
   output logic [WIDX_W-1:0] widx_o
);

   localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(FRAME_WORDS - 1);

   xm_state_e         state;
   logic [WIDX_W-1:0] widx;
   logic [CNT_W-1:0]  fidx, cnt_q;
   logic              wrap;

   assign wrap = (widx == LAST_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= XM_IDLE;
         widx   <= '0;
         fidx   <= '0;
         cnt_q  <= '0;
         cmd_o  <= 1'b0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         cmd_o  <= 1'b0;
         done_o <= 1'b0;
         unique case (state)
            XM_IDLE: begin
               if (start_i) begin
                  if (cfg_ok_i) begin
                     cnt_q <= count_i;
                     fidx  <= '0;
                     widx  <= '0;
                     cmd_o <= 1'b1;
                     err_o <= 1'b0;
                     state <= XM_PAD;
                  end else begin
                     err_o <= 1'b1;
                  end
               end
            end
            XM_PAD: begin
               if (rd_valid_i) begin
                  widx <= wrap ? '0 : widx + WIDX_W'(1);
                  if (wrap) state <= XM_LOAD;
               end
            end
            XM_LOAD: begin
               if (pin_valid_i) begin
                  widx <= wrap ? '0 : widx + WIDX_W'(1);
                  if (wrap) state <= XM_MERGE;
               end
            end
            XM_MERGE: begin
               if (rd_valid_i) begin
                  widx <= wrap ? '0 : widx + WIDX_W'(1);
                  if (wrap) begin
                     if (fidx == cnt_q - CNT_W'(1)) begin
                        state <= XM_TAIL;
                     end else begin
                        fidx  <= fidx + CNT_W'(1);
                        state <= XM_LOAD;
                     end
                  end
               end
            end
            XM_TAIL: begin
               widx <= wrap ? '0 : widx + WIDX_W'(1);
               if (wrap) begin
                  state  <= XM_IDLE;
                  done_o <= 1'b1;
               end
            end
            default: state <= XM_IDLE;
         endcase
      end
   end

   assign accept_o     = (state == XM_IDLE) && start_i && cfg_ok_i;
   assign busy_o       = (state != XM_IDLE);
   assign pin_ready_o  = (state == XM_LOAD);
   assign rd_ready_o   = (state == XM_PAD) || (state == XM_MERGE);
   assign load_fire_o  = (state == XM_LOAD) && pin_valid_i;
   assign merge_fire_o = (state == XM_MERGE) && rd_valid_i;
   assign tail_o       = (state == XM_TAIL);
   assign widx_o       = widx;

endmodule

// File: rtl/cfg_xor_merge.sv
module cfg_xor_merge #(
   parameter int WORD_W    = 32,
   parameter int ROWS      = 4,
   parameter int ROW_WORDS = 2,
   parameter int FADDR_W   = 16,
   parameter int CNT_W     = 8,
   parameter bit SHIFT_EN  = 1'b1,
   localparam int FRAME_WORDS = ROWS * ROW_WORDS,
   localparam int WIDX_W      = $clog2(FRAME_WORDS),
   localparam int ROW_W       = $clog2(ROWS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [FADDR_W-1:0] cfg_first_i,
   input  logic [CNT_W-1:0]   cfg_count_i,
   input  logic [ROW_W-1:0]   cfg_row_lo_i,
   input  logic [ROW_W-1:0]   cfg_row_hi_i,
   input  logic [ROW_W-1:0]   cfg_shift_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   input  logic               pin_valid_i,
   input  logic [WORD_W-1:0]  pin_data_i,
   output logic               pin_ready_o,
   output logic               cp_cmd_o,
   output logic [FADDR_W-1:0] cp_frame_o,
   output logic [CNT_W-1:0]   cp_count_o,
   input  logic               cp_rd_valid_i,
   input  logic [WORD_W-1:0]  cp_rd_data_i,
   output logic               cp_rd_ready_o,
   output logic               cp_wr_valid_o,
   output logic [WORD_W-1:0]  cp_wr_data_o
);

   if (ROWS < 2) begin : g_bad_rows
      $error("cfg_xor_merge: ROWS must be at least 2");
   end
   if (ROW_WORDS < 1) begin : g_bad_rw
      $error("cfg_xor_merge: ROW_WORDS must be at least 1");
   end
   if (WORD_W < 1 || FADDR_W < 1 || CNT_W < 1) begin : g_bad_w
      $error("cfg_xor_merge: widths must be positive");
   end

   localparam logic [ROW_W:0] ROWS_X = (ROW_W+1)'(ROWS);

   logic [ROW_W-1:0]  shift_eff;
   logic              cfg_ok;
   logic              accept, load_fire, merge_fire, tail;
   logic [WIDX_W-1:0] widx, pidx;
   logic              hit;
   logic [WORD_W-1:0] pword, merged;

   logic [FADDR_W-1:0] first_q;
   logic [CNT_W-1:0]   count_q;
   logic [ROW_W-1:0]   lo_q, hi_q, sh_q;

   if (SHIFT_EN) begin : g_shift_on
      assign shift_eff = cfg_shift_i;
   end else begin : g_shift_off
      assign shift_eff = cfg_shift_i & {ROW_W{1'b0}};
   end

   assign cfg_ok = (cfg_count_i != '0) &&
                   (cfg_row_lo_i <= cfg_row_hi_i) &&
                   (({1'b0, cfg_row_hi_i} + {1'b0, shift_eff}) < ROWS_X);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         count_q <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         sh_q    <= '0;
      end else if (accept) begin
         first_q <= cfg_first_i;
         count_q <= cfg_count_i;
         lo_q    <= cfg_row_lo_i;
         hi_q    <= cfg_row_hi_i;
         sh_q    <= shift_eff;
      end
   end

   xm_seq #(
      .FRAME_WORDS(FRAME_WORDS),
      .CNT_W      (CNT_W)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .cfg_ok_i    (cfg_ok),
      .count_i     (cfg_count_i),
      .pin_valid_i (pin_valid_i),
      .rd_valid_i  (cp_rd_valid_i),
      .accept_o    (accept),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o),
      .cmd_o       (cp_cmd_o),
      .pin_ready_o (pin_ready_o),
      .rd_ready_o  (cp_rd_ready_o),
      .load_fire_o (load_fire),
      .merge_fire_o(merge_fire),
      .tail_o      (tail),
      .widx_o      (widx)
   );

   xm_rowmap #(
      .ROWS     (ROWS),
      .ROW_WORDS(ROW_WORDS)
   ) i_rowmap (
      .widx_i (widx),
      .lo_i   (lo_q),
      .hi_i   (hi_q),
      .shift_i(sh_q),
      .hit_o  (hit),
      .pidx_o (pidx)
   );

   xm_pbuf #(
      .WORD_W(WORD_W),
      .DEPTH (FRAME_WORDS)
   ) i_pbuf (
      .clk    (clk),
      .we_i   (load_fire),
      .waddr_i(widx),
      .wdata_i(pin_data_i),
      .raddr_i(pidx),
      .rdata_o(pword)
   );

   assign merged        = cp_rd_data_i ^ (hit ? pword : '0);
   assign cp_wr_valid_o = merge_fire | tail;
   assign cp_wr_data_o  = tail ? '0 : merged;
   assign cp_frame_o    = first_q;
   assign cp_count_o    = count_q;

endmodule

// File: rtl/xm_merge_chk.sv
module xm_merge_chk #(
   parameter int ROWS     = 4,
   parameter int CNT_W    = 8,
   parameter bit SHIFT_EN = 1'b1,
   localparam int ROW_W   = $clog2(ROWS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [CNT_W-1:0] cfg_count_i,
   input logic [ROW_W-1:0] cfg_row_lo_i,
   input logic [ROW_W-1:0] cfg_row_hi_i,
   input logic [ROW_W-1:0] cfg_shift_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             err_o,
   input logic             pin_ready_o,
   input logic             cp_cmd_o,
   input logic             cp_rd_ready_o,
   input logic             cp_wr_valid_o
);

   logic [ROW_W:0] top_row;
   logic           bad_setup;

   assign top_row   = {1'b0, cfg_row_hi_i} + (SHIFT_EN ? {1'b0, cfg_shift_i} : '0);
   assign bad_setup = (cfg_count_i == '0) || (cfg_row_lo_i > cfg_row_hi_i) ||
                      (int'(top_row) >= ROWS);

   assert_cmd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cp_cmd_o |=> !cp_cmd_o);

   assert_cmd_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cp_cmd_o |-> busy_o);

   assert_ready_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cp_rd_ready_o && pin_ready_o));

   assert_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cp_wr_valid_o |-> busy_o);

   assert_done_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && bad_setup) |=> (err_o && !busy_o && !cp_cmd_o));

   assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o);

   assert_ignore_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> !cp_cmd_o);

endmodule

bind cfg_xor_merge xm_merge_chk #(
   .ROWS    (ROWS),
   .CNT_W   (CNT_W),
   .SHIFT_EN(SHIFT_EN)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .cfg_count_i  (cfg_count_i),
   .cfg_row_lo_i (cfg_row_lo_i),
   .cfg_row_hi_i (cfg_row_hi_i),
   .cfg_shift_i  (cfg_shift_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .err_o        (err_o),
   .pin_ready_o  (pin_ready_o),
   .cp_cmd_o     (cp_cmd_o),
   .cp_rd_ready_o(cp_rd_ready_o),
   .cp_wr_valid_o(cp_wr_valid_o)
);

// File: tb/test_cfg_xor_merge.sv
module test_cfg_xor_merge;

   localparam int WW = 32, ROWS = 4, RW = 2, FW = ROWS * RW;
   localparam int FA = 16, CW = 8, RWID = 2;
   localparam int NFR = 16, MAXF = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [FA-1:0]   cfg_first = '0;
   logic [CW-1:0]   cfg_count = '0;
   logic [RWID-1:0] cfg_lo = '0, cfg_hi = '0, cfg_sh = '0;
   logic busy, done, err, pin_ready, cmd, rd_ready, wr_valid;
   logic pin_valid, rd_valid;
   logic [WW-1:0] pin_data, rd_data, wr_data;
   logic [FA-1:0] cp_frame;
   logic [CW-1:0] cp_count;

   cfg_xor_merge i_cfg_xor_merge (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .cfg_first_i(cfg_first), .cfg_count_i(cfg_count),
      .cfg_row_lo_i(cfg_lo), .cfg_row_hi_i(cfg_hi), .cfg_shift_i(cfg_sh),
      .busy_o(busy), .done_o(done), .err_o(err),
      .pin_valid_i(pin_valid), .pin_data_i(pin_data), .pin_ready_o(pin_ready),
      .cp_cmd_o(cmd), .cp_frame_o(cp_frame), .cp_count_o(cp_count),
      .cp_rd_valid_i(rd_valid), .cp_rd_data_i(rd_data), .cp_rd_ready_o(rd_ready),
      .cp_wr_valid_o(wr_valid), .cp_wr_data_o(wr_data)
   );

   logic [WW-1:0] mem [NFR*FW];
   logic [WW-1:0] expm [NFR*FW];
   logic [WW-1:0] snap [NFR*FW];
   logic [WW-1:0] part [MAXF*FW];
   logic [WW-1:0] p1 [MAXF*FW];
   logic [WW-1:0] p2 [MAXF*FW];

   int act = 0, rd_pos = 0, pp = 0, wcnt = 0, m_first = 0, m_count = 0;
   int pad_bad = 0, cmd_seen = 0, done_seen = 0, last_frame = 0, last_count = 0;
   int checks = 0, fails = 0;

   assign rd_valid  = (act != 0) && (rd_pos < (m_count + 1) * FW);
   assign pin_valid = (act != 0) && (pp < m_count * FW);
   assign pin_data  = (pp < MAXF * FW) ? part[pp] : '0;
   always_comb begin
      if (rd_pos < FW) rd_data = 32'hBAD0_0000 | rd_pos;
      else if ((m_first + rd_pos / FW - 1) < NFR)
         rd_data = mem[(m_first + rd_pos / FW - 1) * FW + rd_pos % FW];
      else rd_data = '0;
   end

   always @(posedge clk) begin
      if (cmd) begin
         act <= 1; m_first <= int'(cp_frame); m_count <= int'(cp_count);
         rd_pos <= 0; pp <= 0; wcnt <= 0;
         cmd_seen <= cmd_seen + 1;
         last_frame <= int'(cp_frame); last_count <= int'(cp_count);
      end else begin
         if (rd_valid && rd_ready) rd_pos <= rd_pos + 1;
         if (pin_valid && pin_ready) pp <= pp + 1;
      end
      if (wr_valid) begin
         if (wcnt < m_count * FW) mem[(m_first + wcnt / FW) * FW + wcnt % FW] <= wr_data;
         else if (wr_data != '0) pad_bad <= pad_bad + 1;
         wcnt <= wcnt + 1;
      end
      if (done) done_seen <= done_seen + 1;
   end

   task automatic chk(input bit ok, input string tag, input logic [WW-1:0] a, input logic [WW-1:0] e);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
      end
   endtask

   task automatic model(input int first, input int count, input int lo, input int hi, input int sh);
      for (int f = 0; f < count; f++)
         for (int i = 0; i < FW; i++) begin
            int row = i / RW;
            if (row >= sh && row - sh >= lo && row - sh <= hi)
               expm[(first + f) * FW + i] ^= part[f * FW + i - sh * RW];
         end
   endtask

   task automatic check_mem(input string tag);
      int bad = 0;
      for (int k = 0; k < NFR * FW; k++)
         if (mem[k] !== expm[k]) begin
            if (bad == 0) chk(1'b0, tag, mem[k], expm[k]);
            bad++;
         end
      if (bad == 0) chk(1'b1, tag, '0, '0);
   endtask

   task automatic take_snap();
      for (int k = 0; k < NFR * FW; k++) snap[k] = mem[k];
   endtask

   task automatic check_snap(input string tag);
      int bad = 0;
      for (int k = 0; k < NFR * FW; k++)
         if (mem[k] !== snap[k]) begin
            if (bad == 0) chk(1'b0, tag, mem[k], snap[k]);
            bad++;
         end
      if (bad == 0) chk(1'b1, tag, '0, '0);
   endtask

   task automatic run_op(input int first, input int count, input int lo, input int hi,
                         input int sh, input bit stray);
      int c0 = cmd_seen, d0 = done_seen, pb0 = pad_bad, guard = 0;
      @(negedge clk);
      cfg_first = FA'(first); cfg_count = CW'(count);
      cfg_lo = RWID'(lo); cfg_hi = RWID'(hi); cfg_sh = RWID'(sh);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
      if (stray) begin
         repeat (3) @(negedge clk);
         cfg_first = '0; cfg_count = 8'd1; cfg_lo = '0; cfg_hi = '0; cfg_sh = '0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (done_seen == d0 && guard < 2000) begin @(negedge clk); guard++; end
      repeat (3) @(negedge clk);
      chk(cmd_seen - c0 == 1, "R2 one command", 32'(cmd_seen - c0), 1);
      if (stray) chk(cmd_seen - c0 == 1, "R12 start while busy ignored", 32'(cmd_seen - c0), 1);
      chk(last_frame == first && last_count == count, "R2 command fields",
          32'(last_frame), 32'(first));
      chk(done_seen - d0 == 1, "R9 single done", 32'(done_seen - d0), 1);
      chk(busy == 1'b0, "R9 idle after done", 32'(busy), 0);
      chk(rd_pos == (count + 1) * FW, "R3 readback words consumed", 32'(rd_pos), 32'((count + 1) * FW));
      chk(pp == count * FW, "R4 partial words taken", 32'(pp), 32'(count * FW));
      chk(wcnt == (count + 1) * FW && pad_bad == pb0, "R8 trailing pad", 32'(wcnt),
          32'((count + 1) * FW));
      model(first, count, lo, hi, sh);
   endtask

   task automatic run_bad(input int count, input int lo, input int hi, input int sh);
      int c0 = cmd_seen;
      @(negedge clk);
      cfg_count = CW'(count); cfg_lo = RWID'(lo); cfg_hi = RWID'(hi); cfg_sh = RWID'(sh);
      cfg_first = FA'(1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(err == 1'b1, "R10 err set", 32'(err), 1);
      chk(busy == 1'b0, "R10 no busy", 32'(busy), 0);
      repeat (6) @(negedge clk);
      chk(cmd_seen == c0, "R10 no command", 32'(cmd_seen - c0), 0);
      check_mem("R10 memory untouched");
   endtask

   task automatic fill_part(input int zero_mod);
      for (int k = 0; k < MAXF * FW; k++)
         part[k] = (($urandom % zero_mod) == 0) ? '0 : $urandom;
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int k = 0; k < NFR * FW; k++) begin
         mem[k] = $urandom; expm[k] = mem[k];
      end
      repeat (3) @(negedge clk);
      chk(!busy && !done && !err && !cmd && !rd_ready && !pin_ready && !wr_valid,
          "R1 reset outputs", {25'd0, busy, done, err, cmd, rd_ready, pin_ready, wr_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !cmd && !wr_valid, "R1 idle after reset", 32'(busy), 0);

      // R5 R6: window rows 0..1, no shift
      fill_part(5);
      run_op(2, 3, 0, 1, 0, 1'b0);
      check_mem("R5 window merge");
      // R11: repeat restores
      take_snap();
      run_op(5, 2, 1, 2, 1, 1'b0);
      check_mem("R7 shifted merge");
      run_op(5, 2, 1, 2, 1, 1'b0);
      check_snap("R11 repeat restores");
      // R6: narrow window, everything else untouched
      fill_part(1000);
      run_op(10, 1, 3, 3, 0, 1'b0);
      check_mem("R6 rows outside window");

      // R10 rejections
      run_bad(2, 1, 2, 2);
      run_bad(0, 0, 1, 0);
      run_bad(1, 2, 1, 0);
      run_op(0, 1, 0, 0, 3, 1'b0);
      chk(err == 1'b0, "R10 err cleared", 32'(err), 0);
      check_mem("R7 top row shift");

      // R12: stray start during busy
      fill_part(3);
      run_op(12, 4, 0, 3, 0, 1'b1);
      check_mem("R12 merge unaffected");

      // R13: two passes, removed in reverse
      take_snap();
      for (int k = 0; k < MAXF * FW; k++) begin p1[k] = $urandom; p2[k] = $urandom; end
      for (int k = 0; k < MAXF * FW; k++) part[k] = p1[k];
      run_op(8, 2, 0, 0, 1, 1'b0);
      for (int k = 0; k < MAXF * FW; k++) part[k] = p2[k];
      run_op(8, 2, 1, 2, 0, 1'b0);
      check_mem("R13 two passes loaded");
      run_op(8, 2, 1, 2, 0, 1'b0);
      for (int k = 0; k < MAXF * FW; k++) part[k] = p1[k];
      run_op(8, 2, 0, 0, 1, 1'b0);
      check_snap("R13 reverse removal");

      // random legal operations
      for (int n = 0; n < 10; n++) begin
         int cnt = 1 + int'($urandom % MAXF);
         int fst = int'($urandom % (NFR - cnt + 1));
         int sh = int'($urandom % ROWS);
         int lo = int'($urandom % (ROWS - sh));
         int hi = lo + int'($urandom % (ROWS - sh - lo));
         fill_part(4);
         run_op(fst, cnt, lo, hi, sh, 1'b0);
         check_mem("R5 random merge");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule